// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the program counter of a single-issue core and decides, once per accepted instruction, where execution goes next. The decode stage gives it a 4-bit instruction class, the first comparison operand, a second register operand, an 8-bit immediate with a select flag, a signed relative offset and an absolute jump target. The unit selects the compare operand and evaluates the branch condition. It then forms one of three candidate addresses (sequential, relative, absolute) and loads the chosen one into the PC on the clock edge that retires the instruction.

Compare-and-branch instructions compare the selected operand against the first operand as unsigned quantities. The selected operand stands on the left of the relation. Bit-test branches examine one bit of the first operand, chosen by the low bits of the selected operand. Jump-and-link presents a return address with a write strobe in the same cycle that the PC takes the jump, so the register file can capture it on that edge. All PC arithmetic wraps modulo 2^PC_W.

Top module: `npc_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is RESET_PC (default 16'h0000). After reset is released, `pc` stays there until the first accepted instruction.
- R2: When `insn_valid` is low, `pc` keeps its value across the clock edge and `link_we` is 0, whatever the class code.
- R3: The compare operand is `imm8` zero-extended to DATA_W when `use_imm` is 1, and `op2_reg` when `use_imm` is 0.
- R4: Class codes 1 to 6 are conditional branches, taken when the compare operand is, unsigned, greater than (1), greater or equal to (2), less than (3), less or equal to (4), equal to (5) or not equal to (6) `op1`.
- R5: A taken branch loads `pc + sign_extend(br_ofs)`. A branch that is not taken loads `pc + 1`.
- R6: Class 7 always loads `pc + sign_extend(br_ofs)`, whatever the operands.
- R7: Class 8 is taken when bit `op2[4:0]` of `op1` is 1. Class 9 is taken when that bit is 0. Higher compare-operand bits do not affect the index.
- R8: Class 10 loads `jmp_imm` when `use_imm` is 1, or `op2_reg[15:0]` when `use_imm` is 0.
- R9: Class 11 loads the same target as class 10. In the cycle the instruction is accepted, it drives `link_we` = 1 and `link_data` = `pc + 1` zero-extended to DATA_W.
- R10: Class codes 0 and 12 to 15 advance `pc` by 1.
- R11: Every PC sum wraps modulo 2^16: 16'hFFFF + 1 gives 16'h0000, and a negative offset below address 0 wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction retires this cycle; the PC updates at the edge |
| op_class | input | 4 | Instruction class code (see R4 to R10) |
| use_imm | input | 1 | Selects the immediate forms of the compare operand and jump target |
| op1 | input | 32 | First operand (compared value, bit-test source) |
| op2_reg | input | 32 | Second register operand |
| imm8 | input | 8 | Short immediate compare operand |
| br_ofs | input | 10 | Signed relative branch offset |
| jmp_imm | input | 16 | Absolute jump target immediate |
| pc | output | 16 | Current program counter |
| link_we | output | 1 | Return-address write strobe |
| link_data | output | 32 | Return address, pc + 1 zero-extended |

## Verification
A wrong condition decode, a swapped comparison or a signed compare appears at `pc` one edge after the instruction. The PC is one past the current address when it should equal the relative target, or the reverse. A missing sign extension or a lost carry at the top of the address space shows as a `pc` far from the expected value on the following edge. The next sequential step makes that error permanent, and every later check repeats it. Link errors show in the same cycle, on `link_we` and `link_data`, before the edge that retires the instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [3:0] {
      CLS_SEQ     = 4'd0,
      CLS_BGT     = 4'd1,
      CLS_BGE     = 4'd2,
      CLS_BLT     = 4'd3,
      CLS_BLE     = 4'd4,
      CLS_BEQ     = 4'd5,
      CLS_BNE     = 4'd6,
      CLS_BALWAYS = 4'd7,
      CLS_BBITSET = 4'd8,
      CLS_BBITCLR = 4'd9,
      CLS_JUMP    = 4'd10,
      CLS_JLINK   = 4'd11
   } npc_class_e;

   typedef enum logic [1:0] {
      SRC_SEQ = 2'd0,
      SRC_REL = 2'd1,
      SRC_ABS = 2'd2
   } npc_src_e;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 0
) (
   input  npc_class_e          cls,
   input  logic [DATA_W-1:0]   lhs,
   input  logic [DATA_W-1:0]   rhs,
   output logic                taken
);
   localparam int IDX_W = $clog2(DATA_W);

   logic lt, eq, gt;
   logic bit_sel;

   generate
      if (CMP_STYLE == 0) begin : g_shared_sub
         logic [DATA_W:0] diff;
         assign diff = {1'b0, lhs} - {1'b0, rhs};
         assign lt   = diff[DATA_W];
         assign eq   = (diff[DATA_W-1:0] == '0);
         assign gt   = !lt && !eq;
      end else begin : g_direct_cmp
         assign lt = (lhs < rhs);
         assign eq = (lhs == rhs);
         assign gt = (lhs > rhs);
      end
   endgenerate

   assign bit_sel = rhs[lhs[IDX_W-1:0]];

   always_comb begin
      unique case (cls)
         CLS_BGT:     taken = gt;
         CLS_BGE:     taken = gt || eq;
         CLS_BLT:     taken = lt;
         CLS_BLE:     taken = lt || eq;
         CLS_BEQ:     taken = eq;
         CLS_BNE:     taken = !eq;
         CLS_BALWAYS: taken = 1'b1;
         CLS_BBITSET: taken = bit_sel;
         CLS_BBITCLR: taken = !bit_sel;
         default:     taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
   parameter int PC_W  = 16,
   parameter int OFS_W = 10
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFS_W-1:0] ofs,
   input  logic [PC_W-1:0]  abs_tgt,
   output logic [PC_W-1:0]  seq_tgt,
   output logic [PC_W-1:0]  rel_tgt,
   output logic [PC_W-1:0]  jmp_tgt
);
   logic [PC_W-1:0] ofs_ext;

   generate
      if (OFS_W < PC_W) begin : g_sext
         assign ofs_ext = {{(PC_W-OFS_W){ofs[OFS_W-1]}}, ofs};
      end else begin : g_full
         assign ofs_ext = ofs[PC_W-1:0];
      end
   endgenerate

   assign seq_tgt = pc + {{(PC_W-1){1'b0}}, 1'b1};
   assign rel_tgt = pc + ofs_ext;
   assign jmp_tgt = abs_tgt;
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
   parameter int              PC_W     = 16,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PC_W-1:0] d,
   output logic [PC_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_PC;
      else if (load) q <= d;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
   import npc_pkg::*;
#(
   parameter int              PC_W      = 16,
   parameter int              DATA_W    = 32,
   parameter int              IMM_W     = 8,
   parameter int              OFS_W     = 10,
   parameter int              CMP_STYLE = 0,
   parameter logic [PC_W-1:0] RESET_PC  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [3:0]        op_class,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] op1,
   input  logic [DATA_W-1:0] op2_reg,
   input  logic [IMM_W-1:0]  imm8,
   input  logic [OFS_W-1:0]  br_ofs,
   input  logic [PC_W-1:0]   jmp_imm,
   output logic [PC_W-1:0]   pc,
   output logic              link_we,
   output logic [DATA_W-1:0] link_data
);
   generate
      if (PC_W > DATA_W) begin : g_err_pcw
         $error("PC_W must not exceed DATA_W");
      end
      if (IMM_W > DATA_W) begin : g_err_immw
         $error("IMM_W must not exceed DATA_W");
      end
      if (OFS_W > PC_W || OFS_W < 2) begin : g_err_ofsw
         $error("OFS_W must be within 2..PC_W");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_err_cmp
         $error("CMP_STYLE must be 0 or 1");
      end
   endgenerate

   npc_class_e        cls;
   logic [DATA_W-1:0] cmp_opnd;
   logic [PC_W-1:0]   abs_sel;
   logic [PC_W-1:0]   seq_tgt, rel_tgt, jmp_tgt;
   logic [PC_W-1:0]   pc_next;
   logic              taken;
   npc_src_e          src;

   assign cls      = npc_class_e'(op_class);
   assign cmp_opnd = use_imm ? DATA_W'(imm8) : op2_reg;
   assign abs_sel  = use_imm ? jmp_imm : op2_reg[PC_W-1:0];

   npc_cond_eval #(.DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE)) u_cond (
      .cls   (cls),
      .lhs   (cmp_opnd),
      .rhs   (op1),
      .taken (taken)
   );

   npc_target_gen #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
      .pc      (pc),
      .ofs     (br_ofs),
      .abs_tgt (abs_sel),
      .seq_tgt (seq_tgt),
      .rel_tgt (rel_tgt),
      .jmp_tgt (jmp_tgt)
   );

   always_comb begin
      if (cls == CLS_JUMP || cls == CLS_JLINK) src = SRC_ABS;
      else if (taken)                         src = SRC_REL;
      else                                    src = SRC_SEQ;
   end

   always_comb begin
      unique case (src)
         SRC_REL: pc_next = rel_tgt;
         SRC_ABS: pc_next = jmp_tgt;
         default: pc_next = seq_tgt;
      endcase
   end

   npc_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (insn_valid),
      .d     (pc_next),
      .q     (pc)
   );

   assign link_we   = insn_valid && (cls == CLS_JLINK);
   assign link_data = DATA_W'(seq_tgt);

   assert_nolink_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> !link_we);

   assert_seq_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid && (op_class == 4'd0 || op_class >= 4'd12)
      |=> pc == PC_W'($past(pc) + 1'b1));

   assert_always_rel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid && cls == CLS_BALWAYS |=> pc == $past(rel_tgt));

   assert_eq_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid && cls == CLS_BEQ && cmp_opnd == op1 |=> pc == $past(rel_tgt));

   assert_jump_abs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid && (cls == CLS_JUMP || cls == CLS_JLINK) |=> pc == $past(abs_sel));

   assert_link_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> pc == $past(abs_sel) && $past(link_data) == DATA_W'(PC_W'($past(pc) + 1'b1)));
endmodule

// File: tb/tb_npc_branch_unit.sv
module tb_npc_branch_unit;
   localparam int PC_W = 16, DATA_W = 32, IMM_W = 8, OFS_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              insn_valid = 1'b0;
   logic [3:0]        op_class = '0;
   logic              use_imm = 1'b0;
   logic [DATA_W-1:0] op1 = '0, op2_reg = '0;
   logic [IMM_W-1:0]  imm8 = '0;
   logic [OFS_W-1:0]  br_ofs = '0;
   logic [PC_W-1:0]   jmp_imm = '0;
   logic [PC_W-1:0]   pc;
   logic              link_we;
   logic [DATA_W-1:0] link_data;

   always #4 clk = ~clk;

   npc_branch_unit dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .op_class(op_class),
      .use_imm(use_imm), .op1(op1), .op2_reg(op2_reg), .imm8(imm8),
      .br_ofs(br_ofs), .jmp_imm(jmp_imm), .pc(pc), .link_we(link_we),
      .link_data(link_data)
   );

   typedef struct {
      logic [PC_W-1:0]   pc;
      logic              lwe;
      logic [DATA_W-1:0] ldata;
      string             tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0;
   logic [PC_W-1:0] model_pc;

   function automatic logic [PC_W-1:0] next_pc(
         input logic [PC_W-1:0] cur, input logic v, input logic [3:0] c,
         input logic ui, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] r,
         input logic [7:0] im, input logic [OFS_W-1:0] o, input logic [PC_W-1:0] j);
      logic [DATA_W-1:0] b;
      logic [PC_W-1:0]   rel;
      logic              t;
      if (!v) return cur;
      b   = ui ? {24'd0, im} : r;
      rel = cur + {{(PC_W-OFS_W){o[OFS_W-1]}}, o};
      case (c)
         4'd1:  t = b >  a;
         4'd2:  t = b >= a;
         4'd3:  t = b <  a;
         4'd4:  t = b <= a;
         4'd5:  t = b == a;
         4'd6:  t = b != a;
         4'd7:  t = 1'b1;
         4'd8:  t = a[b[4:0]];
         4'd9:  t = !a[b[4:0]];
         default: t = 1'b0;
      endcase
      if (c == 4'd10 || c == 4'd11) return ui ? j : r[PC_W-1:0];
      return t ? rel : cur + 16'd1;
   endfunction

   task automatic drive(input string tag, input logic v, input logic [3:0] c,
         input logic ui, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] r,
         input logic [7:0] im, input logic [OFS_W-1:0] o, input logic [PC_W-1:0] j);
      exp_t e;
      @(negedge clk);
      insn_valid = v; op_class = c; use_imm = ui; op1 = a; op2_reg = r;
      imm8 = im; br_ofs = o; jmp_imm = j;
      e.lwe   = v && (c == 4'd11);
      e.ldata = {16'd0, model_pc + 16'd1};
      model_pc = next_pc(model_pc, v, c, ui, a, r, im, o, j);
      e.pc  = model_pc;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   always @(posedge clk) begin
      logic              s_lwe;
      logic [DATA_W-1:0] s_ldata;
      exp_t              e;
      s_lwe   = link_we;
      s_ldata = link_data;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         n_chk++;
         if (pc !== e.pc) begin
            n_bad++;
            $display("FAIL %s pc: actual %h expected %h", e.tag, pc, e.pc);
         end
         if (s_lwe !== e.lwe || (e.lwe && s_ldata !== e.ldata)) begin
            n_bad++;
            $display("FAIL %s link: actual we=%b data=%h expected we=%b data=%h",
                     e.tag, s_lwe, s_ldata, e.lwe, e.ldata);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      model_pc = 16'h0000;
      repeat (3) @(posedge clk);
      #1;
      n_chk++;
      if (pc !== 16'h0000) begin
         n_bad++;
         $display("FAIL R1 reset pc: actual %h expected 0000", pc);
      end
      @(negedge clk) rst_n = 1'b1;
      // R1: no instruction yet, pc stays
      drive("R1_hold_after_reset", 0, 4'd0, 0, 0, 0, 0, 0, 0);
      // R2: invalid with jump-and-link class must neither move pc nor link
      drive("R2_idle_jlink",  0, 4'd11, 1, 0, 0, 0, 0, 16'h4000);
      drive("R10_class0",     1, 4'd0,  0, 0, 0, 0, 0, 0);
      drive("R10_class13",    1, 4'd13, 1, 0, 0, 0, 10'd50, 16'h7000);
      // R3 R4 R5: greater-than, immediate operand, taken
      drive("R4_gt_imm_taken",  1, 4'd1, 1, 32'd5, 32'd0, 8'd9, 10'd20, 0);
      drive("R4_gt_reg_nottaken", 1, 4'd1, 0, 32'd9, 32'd9, 8'd200, 10'd20, 0);
      drive("R4_ge_equal",      1, 4'd2, 0, 32'd9, 32'd9, 0, 10'd4, 0);
      // unsigned: 1 < 0xFFFFFFF0
      drive("R4_lt_unsigned",   1, 4'd3, 0, 32'hFFFF_FFF0, 32'd1, 0, 10'd8, 0);
      drive("R4_le_nottaken",   1, 4'd4, 0, 32'd3, 32'd7, 0, 10'd8, 0);
      // R3: imm zero-extended, reg ignored
      drive("R3_eq_imm_zext",   1, 4'd5, 1, 32'h80, 32'hDEAD_0080, 8'h80, 10'd12, 0);
      drive("R3_eq_reg_sel",    1, 4'd5, 0, 32'h80, 32'hDEAD_0080, 8'h80, 10'd12, 0);
      drive("R4_ne_taken",      1, 4'd6, 0, 32'd1, 32'd2, 0, 10'h3F0, 0);
      drive("R6_always_neg",    1, 4'd7, 0, 32'd1, 32'd1, 0, 10'h3FE, 0);
      // R7: index masked to 5 bits (0x3F -> 31)
      drive("R7_bitset_31",     1, 4'd8, 0, 32'h8000_0000, 32'h3F, 0, 10'd6, 0);
      drive("R7_bitset_clear",  1, 4'd8, 1, 32'h0000_0001, 0, 8'h21, 10'd6, 0);
      drive("R7_bitclr_taken",  1, 4'd9, 1, 32'hFFFF_FFFD, 0, 8'h01, 10'd16, 0);
      drive("R8_jump_imm",      1, 4'd10, 1, 0, 32'hABCD_1234, 0, 0, 16'h2222);
      drive("R8_jump_reg",      1, 4'd10, 0, 0, 32'hABCD_1234, 0, 0, 16'h2222);
      drive("R9_jlink_imm",     1, 4'd11, 1, 0, 0, 0, 0, 16'hFFFF);
      drive("R11_wrap_seq",     1, 4'd0, 0, 0, 0, 0, 0, 0);
      drive("R9_jlink_reg",     1, 4'd11, 0, 0, 32'h0000_0003, 0, 0, 16'h9999);
      drive("R11_wrap_neg_ofs", 1, 4'd7, 0, 0, 0, 0, 10'h3F8, 0);
      drive("R11_wrap_pos_ofs", 1, 4'd7, 0, 0, 0, 0, 10'd10, 0);
      drive("R2_idle_end",      0, 4'd7, 0, 0, 0, 0, 10'd10, 0);
      @(negedge clk);
      insn_valid = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule